// File: doc/BRIEF.md
# Presettable Down Counter

This block is a binary down counter, eight bits wide by default, whose controls are all active low. On each rising clock edge it counts down by one, with 0 wrapping to the all-ones value. A low master reset forces the count to the all-ones value without waiting for a clock. A low asynchronous load forces the jam word into the counter at once. A low synchronous load takes the jam word on the next rising edge.

An active-low enable input does two things. It gates counting, and it gates the active-low terminal-count output, which is low only while the count is zero and the enable is low. Because of this, stages can be chained: the terminal-count output of one stage drives the enable of the next, and the chain forms a longer counter. If the terminal-count output is fed back into the synchronous load, the stage becomes a programmable divider that produces one output pulse every N+1 clocks.

The current count is also brought out on a port so it can be observed.

Top module: `preset_down_counter`

## Requirements
- R1: With reset, asynchronous load and synchronous load all high and `en_n` low, each rising clock edge lowers `count` by one.
- R2: With `en_n` high and no load or reset active, `count` holds its value across clock edges.
- R3: `zero_n` is low exactly when `count` is 0 and `en_n` is low. It follows `en_n` without waiting for a clock edge, and under steady counting it is low for one clock period.
- R4: With `sload_n` low and `aload_n` high, the next rising edge loads `jam` into `count`, whatever `en_n` is. This also applies at count 0, where the load replaces the wrap.
- R5: While `aload_n` is low, `count` equals `jam` with no clock edge needed. It stays at `jam` across clock edges, and `sload_n`, `en_n` and the clock have no effect on it.
- R6: While `rst_n` is low, `count` is the all-ones value (255 for 8 bits), with no clock edge needed. `zero_n` is high during that time.
- R7: `rst_n` outranks `aload_n`: with both low, `count` is all-ones. When `rst_n` rises while `aload_n` is still low, `count` shows `jam`.
- R8: With no load active and `en_n` low, a count of 0 is followed by the all-ones value, so a full cycle lasts 2^WIDTH clocks.
- R9: `jam` is a plain binary word. Bit WIDTH-1 is the most significant bit, so loading 0x80 and counting once gives 0x7F.
- R10: If `zero_n` is fed back to `sload_n` with `en_n` low and `jam` = N, `zero_n` pulses low once every N+1 clocks.
- R11: Two stages can be cascaded: the lower stage has `en_n` low and its `zero_n` drives the upper stage's `en_n`. The pair then behaves as a 2·WIDTH-bit counter that decrements once per clock, and the upper stage steps only when the lower stage passes through 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low; forces all-ones |
| aload_n | input | 1 | Asynchronous load, active low; forces `jam` into the counter |
| sload_n | input | 1 | Synchronous load, active low; loads `jam` at the next edge |
| en_n | input | 1 | Count and terminal-count enable, active low |
| jam | input | WIDTH | Preset word, bit WIDTH-1 most significant |
| count | output | WIDTH | Current count |
| zero_n | output | 1 | Terminal count, active low: zero count with enable low |

## Verification
The count is the only state. A wrong next-state decision shows up on `count` one clock edge after it is made. That makes the reference model a per-edge priority chain: reset, asynchronous load, synchronous load, enable, decrement. Each edge's result is compared about 1 ns after that edge. The asynchronous paths and the gating of `zero_n` by `en_n` are checked between edges, where a design that secretly waits for a clock would still show its old value. Errors that only appear over long runs, such as a bad wrap or a bad cascade carry, show up as a wrong 16-bit value in the chained pair within a few hundred clocks, and as a wrong spacing between divider pulses.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // Clocked action selected for the next rising edge when no asynchronous
    // control is active.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } pdc_act_e;

endpackage

// File: rtl/pdc_ctrl.sv
module pdc_ctrl (
    input  logic               sload_n,
    input  logic               en_n,
    output pdc_pkg::pdc_act_e  act
);
    import pdc_pkg::*;

    // Synchronous load outranks the enable; the enable gates the step.
    always_comb begin
        if (!sload_n) begin
            act = ACT_LOAD;
        end else if (!en_n) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/pdc_next.sv
module pdc_next #(
    parameter int WIDTH = 8
) (
    input  pdc_pkg::pdc_act_e  act,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   jam,
    output logic [WIDTH-1:0]   nxt
);
    import pdc_pkg::*;

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Subtracting one from zero wraps naturally to all-ones.
    always_comb begin
        unique case (act)
            ACT_LOAD: nxt = jam;
            ACT_STEP: nxt = cur - ONE;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/pdc_term.sv
module pdc_term #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             en_n,
    output logic             zero_n
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    // Combinational on the count and the enable, so a chained stage sees the
    // enable gate without an extra clock of delay.
    always_comb begin
        zero_n = !((cnt == ZERO) && !en_n);
    end

endmodule

// File: rtl/pdc_state_reg.sv
module pdc_state_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aload_n,
    input  logic [WIDTH-1:0] jam,
    input  logic [WIDTH-1:0] cnt_d,
    output logic [WIDTH-1:0] cnt_q
);
    localparam logic [WIDTH-1:0] MAXV = '1;

    // Reset and asynchronous load both act without a clock; reset wins.
    // Each clock edge taken while the load is held low recaptures the jam word.
    always_ff @(posedge clk or negedge rst_n or negedge aload_n) begin
        if (!rst_n) begin
            cnt_q <= MAXV;
        end else if (!aload_n) begin
            cnt_q <= jam;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_RESET_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && aload_n) |-> (cnt_q == MAXV))
        else $error("count not all-ones on leaving reset"); // R6

endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aload_n,
    input  logic             sload_n,
    input  logic             en_n,
    input  logic [WIDTH-1:0] jam,
    output logic [WIDTH-1:0] count,
    output logic             zero_n
);
    import pdc_pkg::*;

    localparam logic [WIDTH-1:0] MAXV = '1;

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cnt_state_t;

    cnt_state_t        state_d;
    cnt_state_t        state_q;
    pdc_act_e          act;
    logic [WIDTH-1:0]  cnt_view;

    pdc_ctrl u_ctrl (
        .sload_n (sload_n),
        .en_n    (en_n),
        .act     (act)
    );

    pdc_next #(.WIDTH(WIDTH)) u_next (
        .act (act),
        .cur (state_q.count),
        .jam (jam),
        .nxt (state_d.count)
    );

    pdc_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .aload_n (aload_n),
        .jam     (jam),
        .cnt_d   (state_d.count),
        .cnt_q   (state_q.count)
    );

    // While the asynchronous load is held, the jam word is shown live even if
    // it moves between clock edges.
    always_comb begin
        if (!rst_n) begin
            cnt_view = MAXV;
        end else if (!aload_n) begin
            cnt_view = jam;
        end else begin
            cnt_view = state_q.count;
        end
    end

    pdc_term #(.WIDTH(WIDTH)) u_term (
        .cnt    (cnt_view),
        .en_n   (en_n),
        .zero_n (zero_n)
    );

    assign count = cnt_view;

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (aload_n && sload_n && !en_n) |=>
        (!aload_n || count == WIDTH'($past(count) - 1'b1)))
        else $error("count did not step down by one"); // R1

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (aload_n && sload_n && en_n) |=> (!aload_n || $stable(count)))
        else $error("count moved while the enable was high"); // R2

    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (aload_n && !sload_n) |=> (!aload_n || count == $past(jam)))
        else $error("synchronous load missed the jam word"); // R4

    AST_TC_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_n && aload_n && sload_n && !en_n) |=> zero_n)
        else $error("terminal count stayed low past one period"); // R3

endmodule

// File: tb/preset_down_counter_tb_top.sv
`timescale 1ns/1ps
module preset_down_counter_tb_top;
    localparam int W = 8;
    localparam logic [W-1:0] MAXV = '1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n, aload_n, sload_n, en_n;
    logic [W-1:0] jam;
    logic [W-1:0] count;
    logic         zero_n;

    preset_down_counter #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .aload_n(aload_n), .sload_n(sload_n),
        .en_n(en_n), .jam(jam), .count(count), .zero_n(zero_n)
    );

    // Second reset for the cascade pair and the divider.
    logic         rst2_n;
    logic [W-1:0] lo_cnt, hi_cnt, div_cnt;
    logic         lo_zn, hi_zn, div_zn;

    preset_down_counter #(.WIDTH(W)) lo_i (
        .clk(clk), .rst_n(rst2_n), .aload_n(1'b1), .sload_n(1'b1),
        .en_n(1'b0), .jam('0), .count(lo_cnt), .zero_n(lo_zn)
    );
    preset_down_counter #(.WIDTH(W)) hi_i (
        .clk(clk), .rst_n(rst2_n), .aload_n(1'b1), .sload_n(1'b1),
        .en_n(lo_zn), .jam('0), .count(hi_cnt), .zero_n(hi_zn)
    );
    preset_down_counter #(.WIDTH(W)) div_i (
        .clk(clk), .rst_n(rst2_n), .aload_n(1'b1), .sload_n(div_zn),
        .en_n(1'b0), .jam(W'(4)), .count(div_cnt), .zero_n(div_zn)
    );

    int checks = 0;
    int errors = 0;

    string        req_q[$];
    logic [W-1:0] cnt_q[$];
    logic         zn_q[$];
    event         sample_ev;
    logic [W-1:0] m_cnt;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compares every queued expectation against the ports.
    initial begin
        forever begin
            @(sample_ev);
            while (req_q.size() > 0) begin
                string        r;
                logic [W-1:0] c;
                logic         z;
                r = req_q.pop_front();
                c = cnt_q.pop_front();
                z = zn_q.pop_front();
                chk({r, " count"}, 32'(count), 32'(c));
                chk({r, " zero_n"}, 32'(zero_n), 32'(z));
            end
        end
    end

    task automatic push(input string req);
        req_q.push_back(req);
        cnt_q.push_back(m_cnt);
        zn_q.push_back(!((m_cnt == '0) && !en_n));
        -> sample_ev;
    endtask

    task automatic drive(input logic r, input logic a, input logic s,
                         input logic e, input logic [W-1:0] j);
        @(negedge clk);
        rst_n = r; aload_n = a; sload_n = s; en_n = e; jam = j;
    endtask

    // Asynchronous expectation, checked between edges.
    task automatic expect_now(input string req);
        #1;
        if (!rst_n) m_cnt = MAXV;
        else if (!aload_n) m_cnt = jam;
        push(req);
    endtask

    // One clock edge applied to the priority model.
    task automatic cycle(input string req);
        @(posedge clk);
        if (!rst_n) m_cnt = MAXV;
        else if (!aload_n) m_cnt = jam;
        else if (!sload_n) m_cnt = jam;
        else if (!en_n) m_cnt = m_cnt - 1'b1;
        #1;
        push(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; aload_n = 1'b1; sload_n = 1'b1; en_n = 1'b1; jam = '0;
        rst2_n = 1'b0;
        m_cnt = '0;
        expect_now("R6 reset value");
        repeat (2) cycle("R6 reset held");

        drive(1, 1, 1, 0, '0);
        repeat (5) cycle("R1 count down");

        drive(1, 1, 1, 1, '0);
        repeat (3) cycle("R2 hold with enable high");

        drive(1, 1, 0, 1, 8'h03);
        cycle("R4 sync load with enable high");
        drive(1, 1, 1, 0, 8'h03);
        repeat (3) cycle("R3 count to zero");
        drive(1, 1, 1, 1, 8'h03);
        expect_now("R3 enable gates terminal count");
        drive(1, 1, 1, 0, 8'h03);
        expect_now("R3 terminal count back low");
        cycle("R8 wrap to all-ones");

        drive(1, 1, 0, 0, 8'h80);
        cycle("R9 load msb word");
        drive(1, 1, 1, 0, 8'h80);
        cycle("R9 msb borrow");

        drive(1, 0, 1, 0, 8'h5A);
        expect_now("R5 async load without clock");
        cycle("R5 async load outranks count");
        drive(1, 0, 0, 1, 8'h5A);
        cycle("R5 async load outranks sync load");
        drive(1, 1, 1, 0, 8'h5A);
        cycle("R1 count after async load");

        drive(1, 0, 1, 1, 8'h11);
        expect_now("R5 async load");
        drive(0, 0, 1, 1, 8'h11);
        expect_now("R7 reset outranks async load");
        drive(1, 0, 1, 1, 8'h11);
        expect_now("R7 async load after reset release");
        cycle("R5 async load held");
        drive(1, 1, 1, 0, 8'h11);
        cycle("R1 count resumes");

        // Cascade pair: 16-bit value decrements once per edge.
        @(negedge clk);
        rst2_n = 1'b1;
        chk("R11 cascade start", {16'h0, hi_cnt, lo_cnt}, 32'hFFFF);
        for (int k = 1; k <= 600; k++) begin
            @(negedge clk);
            chk("R11 cascade value", {16'h0, hi_cnt, lo_cnt}, 32'(16'hFFFF - 16'(k)));
            chk("R11 upper terminal idle", 32'(hi_zn), 32'h1);
        end

        // Divider: jam 4 gives a pulse every 5 clocks.
        for (int i = 0; i < 20 && div_zn; i++) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            int gap;
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
            end while (div_zn && gap < 20);
            chk("R10 divide by N+1 period", 32'(gap), 32'd5);
        end

        #1;
        finish_run();
    end

endmodule